// File: doc/BRIEF.md
# Lock-Protected System Control Registers

This block is the small register file of a board controller. A host reaches it over a plain 32-bit single-cycle read/write bus with a 12-bit byte offset, of which only the word bits are decoded. It holds a fixed identification word and processor ID, an LED register that also drives output pins, two scratch configuration words, and a flag word. A second flag word keeps its contents through the synchronous reset. It also holds a reset-level register and a readout of a counter that advances on a 24 MHz clock-enable strobe.

The reset-level register is protected. It accepts a write only while the lock register holds the exact key value 0xA05F. An accepted write whose bit 8 is set also raises a one-cycle system reset request. Both flag words have a set address and a clear address, so software can change single bits without a read-modify-write.

Top module: `sysctl_regs`

## Requirements
- R1: After `rst_n` is held low for a clock edge, the LED (0x08), lock (0x20), configuration (0x28, 0x2C), flag (0x30) and reset-level (0x40) registers read 0, the `leds` pins are 0 and `reset_req` is low.
- R2: A read of 0x00 returns the `ID_WORD` parameter, 0x84 returns the `PROC_ID` parameter, 0x88 returns 0xFF000000 and 0x44 returns 0x00000001.
- R3: A write to 0x20 with data exactly 0x0000A05F stores 0xA05F. A write of any other data stores the data ANDed with 0x7FFF, so bit 15 and all upper bits read back as 0.
- R4: A write to 0x40 leaves the reset level and `reset_req` unchanged unless the lock register holds 0xA05F at the clock edge of the write.
- R5: An accepted write to 0x40 stores the full data word, which reads back at 0x40. If data bit 8 is 1, `reset_req` is high for exactly the one cycle after that edge. If bit 8 is 0, `reset_req` stays low.
- R6: A read of 0x30 returns the flags. A write to 0x30 sets every flag bit that is 1 in the data, and a write to 0x34 clears every flag bit that is 1 in the data. Bits that are 0 in the data keep their value.
- R7: The non-volatile flags read at 0x38. They are set through 0x38 and cleared through 0x3C in the same way as R6, and they keep their value when `rst_n` is asserted.
- R8: The LED register (0x08) and the configuration words (0x28, 0x2C) are read/write 32-bit registers, and `leds` always equals the LED register.
- R9: The value at 0x5C increases by one on each clock edge at which `tick_en` is high and holds otherwise. It is 0 after reset.
- R10: Oscillator offsets such as 0x0C, the read-only offsets (0x00, 0x84), the clear-only offset 0x34 and unused offsets read as 0 or as their fixed value, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 24 MHz clock-enable strobe for the tick counter |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| leds | output | 32 | LED register contents |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that each access lasts exactly one cycle and is sampled at that cycle's rising edge, and that `bus_addr` is word aligned. They also assume that `tick_en` may be high on any cycle. The stimulus drives all bus signals on the falling edge and holds them for one full cycle. It uses only aligned offsets and keeps `tick_en` low except in the counter test, so table reads of the counter-free registers are deterministic. The non-volatile flags have no reset value, so the stimulus clears them through their clear address before it reads them.

// File: rtl/sysctl_pkg.sv
// Package: shared offsets and constants for the system control register file.
// Assumes byte offsets are word aligned; only bits [11:2] are decoded.
package sysctl_pkg;
    localparam int unsigned        DATA_W   = 32;
    localparam int unsigned        ADDR_W   = 12;
    localparam int unsigned        LOCK_W   = 16;
    localparam logic [31:0]        LOCK_KEY = 32'h0000_A05F;
    localparam logic [31:0]        LOCK_MSK = 32'h0000_7FFF;
    localparam int unsigned        REQ_BIT  = 8;

    localparam logic [ADDR_W-1:0] OFF_IDENT   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_LED     = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CFG_A   = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_CFG_B   = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_FLG_SET = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_FLG_CLR = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_NVF_SET = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_NVF_CLR = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_RSTLVL  = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_BUSCFG  = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_TICKS   = 12'h05C;
    localparam logic [ADDR_W-1:0] OFF_PROC_A  = 12'h084;
    localparam logic [ADDR_W-1:0] OFF_PROC_B  = 12'h088;

    localparam logic [DATA_W-1:0] BUSCFG_VAL = 32'h0000_0001;
    localparam logic [DATA_W-1:0] PROC_B_VAL = 32'hFF00_0000;
endpackage

// File: rtl/sysctl_lock.sv
// Module: key register that opens the reset-level register.
// Assumes wr_en is a single-cycle write strobe already decoded for the lock offset.
// The exact key is stored whole; any other data is stored with its top bit cleared,
// so a non-key write can never leave the register holding the key.
module sysctl_lock
    import sysctl_pkg::*;
#(
    parameter int unsigned W = LOCK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      lock_q,
    output logic              unlocked
);
    localparam logic [W-1:0] KEY_W = LOCK_KEY[W-1:0];
    localparam logic [W-1:0] MSK_W = LOCK_MSK[W-1:0];

    // Purpose: store key exactly, anything else masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (wr_en)
            lock_q <= (wdata == LOCK_KEY) ? KEY_W : (wdata[W-1:0] & MSK_W);
    end

    // Purpose: open indication compared on the stored value.
    always_comb unlocked = (lock_q == KEY_W);

    // R3: a non-key write leaves the top bit clear
    p_mask_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != LOCK_KEY) |=> !lock_q[W-1]);
    // R3: the exact key opens the lock
    p_key_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == LOCK_KEY) |=> unlocked);
endmodule

// File: rtl/sysctl_flags.sv
// Module: one flag word with separate set and clear strobes.
// Assumes set_en and clr_en come from different offsets and are never high together.
// RESETTABLE = 0 builds a word that keeps its value across rst_n.
module sysctl_flags
    import sysctl_pkg::*;
#(
    parameter int unsigned W          = DATA_W,
    parameter bit          RESETTABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    // Purpose: next value from the set and clear strobes.
    always_comb begin
        q_next = q;
        if (set_en)
            q_next = q | wdata;
        else if (clr_en)
            q_next = q & ~wdata;
    end

    generate
        if (RESETTABLE) begin : g_rst
            // Purpose: volatile word, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= q_next;
            end
        end else begin : g_keep
            // Purpose: retained word, ignores reset.
            always_ff @(posedge clk) begin
                q <= q_next;
            end
        end
    endgenerate

    // R6/R7: set writes raise every selected bit
    p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));
    // R6/R7: clear writes drop every selected bit
    p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
    // R6/R7: unselected bits are kept
    p_keep_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/sysctl_tick.sv
// Module: free-running tick counter advanced by a clock-enable strobe.
// Assumes tick_en is synchronous to clk and wraps silently at full scale.
module sysctl_tick
    import sysctl_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] count
);
    // Purpose: count one per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick_en)
            count <= count + 1'b1;
    end

    // R9: one step per strobe
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (count == $past(count) + 1'b1));
    // R9: holds without strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));
endmodule

// File: rtl/sysctl_regs.sv
// Module: top of the system control register file.
// Decodes single-cycle bus accesses, holds the plain registers and the reset-level
// register, and muxes read data. Assumes word-aligned offsets; reads are combinational.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD = 32'h4157_0A11,
    parameter logic [31:0] PROC_ID = 32'h0C00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] leds,
    output logic              reset_req
);
    logic [ADDR_W-1:0] word_off;
    logic              wr;
    logic              we_led, we_lock, we_cfg_a, we_cfg_b;
    logic              we_fset, we_fclr, we_nset, we_nclr, we_rst;
    logic [DATA_W-1:0] led_q, cfg_a_q, cfg_b_q, rst_level;
    logic [DATA_W-1:0] flags_q, nvflags_q, ticks_q;
    logic [LOCK_W-1:0] lock_q;
    logic              unlocked;
    logic [DATA_W-1:0] rd_mux;

    // Purpose: aligned offset and write strobe decode.
    always_comb begin
        word_off = {bus_addr[ADDR_W-1:2], 2'b00};
        wr       = bus_en && bus_we;
        we_led   = wr && (word_off == OFF_LED);
        we_lock  = wr && (word_off == OFF_LOCK);
        we_cfg_a = wr && (word_off == OFF_CFG_A);
        we_cfg_b = wr && (word_off == OFF_CFG_B);
        we_fset  = wr && (word_off == OFF_FLG_SET);
        we_fclr  = wr && (word_off == OFF_FLG_CLR);
        we_nset  = wr && (word_off == OFF_NVF_SET);
        we_nclr  = wr && (word_off == OFF_NVF_CLR);
        we_rst   = wr && (word_off == OFF_RSTLVL);
    end

    // Purpose: plain read/write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= '0;
            cfg_a_q <= '0;
            cfg_b_q <= '0;
        end else begin
            if (we_led)   led_q   <= bus_wdata;
            if (we_cfg_a) cfg_a_q <= bus_wdata;
            if (we_cfg_b) cfg_b_q <= bus_wdata;
        end
    end

    // Purpose: lock-gated reset level and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_level <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= we_rst && unlocked && bus_wdata[REQ_BIT];
            if (we_rst && unlocked)
                rst_level <= bus_wdata;
        end
    end

    sysctl_lock #(.W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(we_lock), .wdata(bus_wdata),
        .lock_q(lock_q), .unlocked(unlocked)
    );

    sysctl_flags #(.W(DATA_W), .RESETTABLE(1'b1)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_en(we_fset), .clr_en(we_fclr),
        .wdata(bus_wdata), .q(flags_q)
    );

    sysctl_flags #(.W(DATA_W), .RESETTABLE(1'b0)) u_nvflags (
        .clk(clk), .rst_n(rst_n), .set_en(we_nset), .clr_en(we_nclr),
        .wdata(bus_wdata), .q(nvflags_q)
    );

    sysctl_tick #(.W(DATA_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(ticks_q)
    );

    // Purpose: read data multiplexer; unlisted offsets read zero.
    always_comb begin
        unique case (word_off)
            OFF_IDENT:   rd_mux = ID_WORD;
            OFF_LED:     rd_mux = led_q;
            OFF_LOCK:    rd_mux = {{(DATA_W-LOCK_W){1'b0}}, lock_q};
            OFF_CFG_A:   rd_mux = cfg_a_q;
            OFF_CFG_B:   rd_mux = cfg_b_q;
            OFF_FLG_SET: rd_mux = flags_q;
            OFF_NVF_SET: rd_mux = nvflags_q;
            OFF_RSTLVL:  rd_mux = rst_level;
            OFF_BUSCFG:  rd_mux = BUSCFG_VAL;
            OFF_TICKS:   rd_mux = ticks_q;
            OFF_PROC_A:  rd_mux = PROC_ID;
            OFF_PROC_B:  rd_mux = PROC_B_VAL;
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: drive outputs.
    always_comb begin
        bus_rdata = (bus_en && !bus_we) ? rd_mux : '0;
        leds      = led_q;
    end

    // R4: a write while locked leaves the level untouched
    p_locked_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rst && !unlocked) |=> $stable(rst_level));
    // R5: a request only follows an accepted write with the request bit
    p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(we_rst && unlocked && bus_wdata[REQ_BIT]));
    // R5: an accepted request write raises the request
    p_req_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rst && unlocked && bus_wdata[REQ_BIT]) |=> reset_req);
    // R8: LED pins follow register writes
    p_led_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_led |=> (leds == $past(bus_wdata)));
endmodule

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;
    localparam logic [31:0] ID   = 32'h4157_0A11;
    localparam logic [31:0] PROC = 32'h0C00_0000;
    localparam int NV = 34;
    // {we, addr, data, expected read}
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 12'h03C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'h000, 32'h0, ID},
        {1'b0, 12'h084, 32'h0, PROC},
        {1'b0, 12'h088, 32'h0, 32'hFF00_0000},
        {1'b0, 12'h044, 32'h0, 32'h0000_0001},
        {1'b1, 12'h008, 32'h0000_00A5, 32'h0},
        {1'b0, 12'h008, 32'h0, 32'h0000_00A5},
        {1'b1, 12'h028, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 12'h028, 32'h0, 32'hDEAD_BEEF},
        {1'b1, 12'h02C, 32'h1234_5678, 32'h0},
        {1'b0, 12'h02C, 32'h0, 32'h1234_5678},
        {1'b1, 12'h030, 32'h0000_F00F, 32'h0},
        {1'b1, 12'h030, 32'h0000_0110, 32'h0},
        {1'b0, 12'h030, 32'h0, 32'h0000_F11F},
        {1'b1, 12'h034, 32'h0000_100F, 32'h0},
        {1'b0, 12'h030, 32'h0, 32'h0000_E110},
        {1'b1, 12'h038, 32'h8000_0001, 32'h0},
        {1'b1, 12'h03C, 32'h0000_0001, 32'h0},
        {1'b0, 12'h038, 32'h0, 32'h8000_0000},
        {1'b1, 12'h020, 32'h0000_FFFF, 32'h0},
        {1'b0, 12'h020, 32'h0, 32'h0000_7FFF},
        {1'b1, 12'h040, 32'h0000_0055, 32'h0},
        {1'b0, 12'h040, 32'h0, 32'h0},
        {1'b1, 12'h020, 32'h0001_A05F, 32'h0},
        {1'b0, 12'h020, 32'h0, 32'h0000_205F},
        {1'b1, 12'h020, 32'h0000_A05F, 32'h0},
        {1'b0, 12'h020, 32'h0, 32'h0000_A05F},
        {1'b1, 12'h040, 32'h0000_0033, 32'h0},
        {1'b0, 12'h040, 32'h0, 32'h0000_0033},
        {1'b1, 12'h00C, 32'h1234_5678, 32'h0},
        {1'b0, 12'h00C, 32'h0, 32'h0},
        {1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'h000, 32'h0, ID},
        {1'b0, 12'h034, 32'h0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] leds;
    logic        reset_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysctl_regs #(.ID_WORD(ID), .PROC_ID(PROC)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .leds(leds), .reset_req(reset_req)
    );

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h008, 12'h028, 12'h02C: return "R8";
            12'h030:                   return "R6";
            12'h038:                   return "R7";
            12'h020:                   return "R3";
            12'h040:                   return "R4";
            12'h000, 12'h084, 12'h088, 12'h044: return "R2";
            default:                   return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: drive on falling edge, return read data before the rising edge
    task automatic bus_cycle(input logic we, input logic [11:0] a, input logic [31:0] d,
                             output logic [31:0] rd);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #2 rd = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] r;
        bus_cycle(1'b0, a, 32'h0, r);
        check(req, r, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r;
        bus_cycle(1'b1, a, d, r);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of volatile registers
        rd_check("R1", 12'h008, 32'h0);
        rd_check("R1", 12'h020, 32'h0);
        rd_check("R1", 12'h028, 32'h0);
        rd_check("R1", 12'h02C, 32'h0);
        rd_check("R1", 12'h030, 32'h0);
        rd_check("R1", 12'h040, 32'h0);
        check("R1", {31'h0, reset_req}, 32'h0);
        check("R1", leds, 32'h0);
        rd_check("R9", 12'h05C, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VEC[i][76], VEC[i][75:64], VEC[i][63:32], r);
            if (!VEC[i][76])
                check(req_of(VEC[i][75:64]), r, VEC[i][31:0]);
        end
        idle();
        check("R8", leds, 32'h0000_00A5);

        // R5: lock is open here; request pulse for one cycle
        wr(12'h040, 32'h0000_0100);
        idle();
        check("R5", {31'h0, reset_req}, 32'h1);
        @(negedge clk);
        check("R5", {31'h0, reset_req}, 32'h0);
        rd_check("R5", 12'h040, 32'h0000_0100);
        wr(12'h040, 32'h0000_00FF);
        idle();
        check("R5", {31'h0, reset_req}, 32'h0);
        rd_check("R5", 12'h040, 32'h0000_00FF);

        // R9: five strobes advance the counter by five, then it holds
        idle();
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd_check("R9", 12'h05C, 32'd5);
        repeat (3) @(negedge clk);
        rd_check("R9", 12'h05C, 32'd5);

        // R7/R1: retained flags survive reset, the rest clears
        wr(12'h038, 32'h0000_00A0);
        wr(12'h030, 32'h0000_0F00);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_check("R7", 12'h038, 32'h8000_00A0);
        rd_check("R1", 12'h030, 32'h0);
        rd_check("R1", 12'h020, 32'h0);
        rd_check("R1", 12'h040, 32'h0);
        rd_check("R1", 12'h008, 32'h0);
        check("R1", leds, 32'h0);

        // R4: after reset the lock is closed; request write is ignored
        wr(12'h040, 32'h0000_0100);
        idle();
        check("R4", {31'h0, reset_req}, 32'h0);
        rd_check("R4", 12'h040, 32'h0);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule